// File: doc/BRIEF.md
# Retirement Trace Packet Encoder

This block sits beside a processor's retirement stage and turns each retired instruction into one fixed 704-bit trace record. It takes the register indices and values, the program counter before and after the instruction, the instruction word, the memory access (address, read and write data, direction and byte count) and the trap, trap-handler-entry and halt events. From these it packs a record of 8-bit flag, index and mask fields and 64-bit data fields.

Fields that describe something the instruction did not do are forced to zero. Byte masks are derived from the access size. A running sequence number is placed in every record. Records leave on a valid/ready port through a single output register. While that register holds a record that has not been taken, the retirement input is stalled.

Top module: `trace_record_enc`

## Requirements
- R1: After reset `out_valid` is 0, `out_rec` is all zeros and `in_ready` is 1; the first accepted retirement carries sequence number 1.
- R2: A retirement is accepted on a rising edge where `in_valid` and `in_ready` are both 1, with `in_ready` = !`out_valid` or `out_ready`. Its record appears on `out_rec` with `out_valid` = 1 in the next cycle. A taken record with no new acceptance drops `out_valid` to 0.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_rec` and `out_valid` hold their values.
- R4: Record layout from bit 0 upward: sequence [63:0], pc before [127:64], pc after [191:128], instruction [255:192] (zero-extended), rs1 value [319:256], rs2 value [383:320], rd value [447:384], memory address [511:448], read data [575:512], write data [639:576], read mask [647:640], write mask [655:648], rs1 index [663:656], rs2 index [671:664], rd index [679:672], trap [687:680], halt [695:688], handler entry [703:696]. Indices are zero-extended to 8 bits.
- R5: For `mem_bytes` = N with 1 ≤ N ≤ 8 the mask has its N low bits set. N = 0 gives mask 0. N from 9 to 15 is treated as 8.
- R6: The read mask and read data are zero unless `mem_rd_en` is 1. The write mask and write data are zero unless `mem_wr_en` is 1. The memory address is zero unless one of the two is 1.
- R7: The rd index field is zero when `rd_we` is 0. The rd value field is zero whenever the rd index field is zero.
- R8: Each source value field is zero when its source index is 0; otherwise it carries the input value.
- R9: The trap, halt and handler-entry fields are 8'h01 when `trap_evt`, `halt_evt` and `handler_entry` are set, and 8'h00 otherwise.
- R10: The sequence field increments by exactly one per accepted retirement; stalled and idle cycles do not advance it.
- R11: The pc before, pc after and instruction fields pass the inputs through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A retirement is presented |
| in_ready | output | 1 | Retirement can be accepted this cycle |
| rs1_idx | input | IDX_W | First source register index |
| rs1_val | input | DATA_W | First source register value |
| rs2_idx | input | IDX_W | Second source register index |
| rs2_val | input | DATA_W | Second source register value |
| rd_we | input | 1 | Instruction writes a destination register |
| rd_idx | input | IDX_W | Destination register index |
| rd_val | input | DATA_W | Destination register value |
| pc_cur | input | DATA_W | PC of the instruction |
| pc_next | input | DATA_W | Next PC (sequential, jump or trap target) |
| insn_word | input | INSN_W | Instruction word |
| mem_rd_en | input | 1 | Instruction read memory |
| mem_wr_en | input | 1 | Instruction wrote memory |
| mem_bytes | input | 4 | Access size in bytes |
| mem_addr | input | DATA_W | Byte address of the access |
| mem_rdata | input | DATA_W | Data read |
| mem_wdata | input | DATA_W | Data written |
| trap_evt | input | 1 | Instruction trapped |
| handler_entry | input | 1 | First instruction of a trap handler |
| halt_evt | input | 1 | Last instruction before halt |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_rec | output | 704 | Trace record |

## Verification
Every result of this block is due exactly one rising edge after its cause. A record, its sequence number and `out_valid` follow the edge that accepted the retirement. `in_ready` is combinational, so it is due in the same cycle as the `out_ready` value it depends on. The bench drives inputs just after the falling edge and samples 2 ns later. It updates its reference on each rising edge from the inputs present there, so at every sample point the model and the design describe the same cycle. Each field is compared separately, so a mismatch names the zeroing or packing rule it belongs to.

// File: rtl/trace_record_enc.sv
module trace_record_enc #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  rs1_idx,
  input  logic [DATA_W-1:0] rs1_val,
  input  logic [IDX_W-1:0]  rs2_idx,
  input  logic [DATA_W-1:0] rs2_val,
  input  logic              rd_we,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_val,
  input  logic [DATA_W-1:0] pc_cur,
  input  logic [DATA_W-1:0] pc_next,
  input  logic [INSN_W-1:0] insn_word,
  input  logic              mem_rd_en,
  input  logic              mem_wr_en,
  input  logic [3:0]        mem_bytes,
  input  logic [DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] mem_wdata,
  input  logic              trap_evt,
  input  logic              handler_entry,
  input  logic              halt_evt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [703:0]      out_rec
);
  localparam int FW = 64;
  localparam int REC_W = 704;

  function automatic logic [7:0] size_mask(input logic [3:0] n);
    logic [3:0] sat;
    sat = (n > 4'd8) ? 4'd8 : n;
    return (sat == 4'd0) ? 8'h00 : (8'hFF >> (4'd8 - sat));
  endfunction

  logic [FW-1:0] order_cnt;
  logic [FW-1:0] order_nxt;
  logic          take;
  logic          mem_any;
  logic [7:0]    rd_f, rs1_f, rs2_f, rmask_f, wmask_f;
  logic [REC_W-1:0] rec_nxt;

  assign in_ready  = !out_valid || out_ready;
  assign take      = in_valid && in_ready;
  assign order_nxt = order_cnt + FW'(1);
  assign mem_any   = mem_rd_en || mem_wr_en;

  assign rd_f    = rd_we ? 8'(rd_idx) : 8'h00;
  assign rs1_f   = 8'(rs1_idx);
  assign rs2_f   = 8'(rs2_idx);
  assign rmask_f = mem_rd_en ? size_mask(mem_bytes) : 8'h00;
  assign wmask_f = mem_wr_en ? size_mask(mem_bytes) : 8'h00;

  assign rec_nxt = {
    8'(handler_entry), 8'(halt_evt), 8'(trap_evt),
    rd_f, rs2_f, rs1_f, wmask_f, rmask_f,
    mem_wr_en ? FW'(mem_wdata) : FW'(0),
    mem_rd_en ? FW'(mem_rdata) : FW'(0),
    mem_any   ? FW'(mem_addr)  : FW'(0),
    (rd_f != 8'h00) ? FW'(rd_val) : FW'(0),
    (rs2_f != 8'h00) ? FW'(rs2_val) : FW'(0),
    (rs1_f != 8'h00) ? FW'(rs1_val) : FW'(0),
    FW'(insn_word), FW'(pc_next), FW'(pc_cur),
    order_nxt
  };

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rec   <= '0;
      order_cnt <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_rec   <= rec_nxt;
      order_cnt <= order_nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R3
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rec)));

  // R10
  order_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (out_rec[63:0] == $past(order_cnt) + 64'd1));

  // R7
  rd_zero_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rec[679:672] == 8'h00) |-> (out_rec[447:384] == 64'd0));

  // R8
  rs1_zero_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rec[663:656] == 8'h00) |-> (out_rec[319:256] == 64'd0));

  // R8
  rs2_zero_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rec[671:664] == 8'h00) |-> (out_rec[383:320] == 64'd0));

  // R5
  mask_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((out_rec[647:640] & (out_rec[647:640] + 8'd1)) == 8'h00) &&
                   ((out_rec[655:648] & (out_rec[655:648] + 8'd1)) == 8'h00)));

  // R6
  addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !mem_rd_en && !mem_wr_en) |=> (out_rec[655:640] == 16'h0 && out_rec[511:448] == 64'd0));

  // R9
  halt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && halt_evt) |=> (out_rec[695:688] == 8'h01));
endmodule

// File: tb/trace_record_enc_tb.sv
module trace_record_enc_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, in_ready, rd_we, mem_rd_en, mem_wr_en;
  logic trap_evt, handler_entry, halt_evt, out_valid, out_ready;
  logic [4:0] rs1_idx, rs2_idx, rd_idx;
  logic [63:0] rs1_val, rs2_val, rd_val, pc_cur, pc_next, mem_addr, mem_rdata, mem_wdata;
  logic [31:0] insn_word;
  logic [3:0] mem_bytes;
  logic [703:0] out_rec;

  trace_record_enc u_dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  logic m_valid;
  logic [703:0] m_rec, prev_rec;
  longint unsigned m_seq;
  logic prev_stall;

  function automatic logic [703:0] expect_rec(longint unsigned seq);
    logic [703:0] r;
    logic [7:0] mk;
    int nb;
    r = '0;
    nb = (mem_bytes > 8) ? 8 : int'(mem_bytes);
    mk = 8'h00;
    for (int k = 0; k < nb; k++) mk[k] = 1'b1;
    r[63:0]    = seq;
    r[127:64]  = pc_cur;
    r[191:128] = pc_next;
    r[255:192] = {32'd0, insn_word};
    if (rs1_idx != 0) r[319:256] = rs1_val;
    if (rs2_idx != 0) r[383:320] = rs2_val;
    if (rd_we && rd_idx != 0) begin
      r[447:384] = rd_val;
      r[679:672] = {3'd0, rd_idx};
    end
    if (mem_rd_en || mem_wr_en) r[511:448] = mem_addr;
    if (mem_rd_en) begin r[575:512] = mem_rdata; r[647:640] = mk; end
    if (mem_wr_en) begin r[639:576] = mem_wdata; r[655:648] = mk; end
    r[663:656] = {3'd0, rs1_idx};
    r[671:664] = {3'd0, rs2_idx};
    r[687:680] = trap_evt ? 8'h01 : 8'h00;
    r[695:688] = halt_evt ? 8'h01 : 8'h00;
    r[703:696] = handler_entry ? 8'h01 : 8'h00;
    return r;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_field(string req, string what, int lo, int w);
    logic [63:0] a, e, m;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    a = 64'(out_rec >> lo) & m;
    e = 64'(m_rec >> lo) & m;
    check(req, what, a, e);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_rec = '0; m_seq = 0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      m_seq++;
      m_rec = expect_rec(m_seq);
      m_valid = 1;
    end else if (out_ready) m_valid = 0;
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      check("R2", "out_valid", 64'(out_valid), 64'(m_valid));
      check("R2", "in_ready", 64'(in_ready), 64'(!m_valid || out_ready));
      if (prev_stall) begin
        check("R3", "held valid", 64'(out_valid), 64'd1);
        check("R3", "held record", 64'(out_rec != prev_rec), 64'd0);
      end
      if (m_valid) begin
        cmp_field("R10", "sequence", 0, 64);
        cmp_field("R11", "pc before", 64, 64);
        cmp_field("R11", "pc after", 128, 64);
        cmp_field("R11", "instruction", 192, 64);
        cmp_field("R8", "rs1 value", 256, 64);
        cmp_field("R8", "rs2 value", 320, 64);
        cmp_field("R7", "rd value", 384, 64);
        cmp_field("R6", "mem address", 448, 64);
        cmp_field("R6", "read data", 512, 64);
        cmp_field("R6", "write data", 576, 64);
        cmp_field("R5", "read mask", 640, 8);
        cmp_field("R5", "write mask", 648, 8);
        cmp_field("R4", "rs1 index", 656, 8);
        cmp_field("R4", "rs2 index", 664, 8);
        cmp_field("R7", "rd index", 672, 8);
        cmp_field("R9", "trap", 680, 8);
        cmp_field("R9", "halt", 688, 8);
        cmp_field("R9", "handler entry", 696, 8);
      end
      prev_stall = out_valid && !out_ready;
      prev_rec = out_rec;
    end
  end

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  task automatic randomize_inputs(int pv, int pr);
    in_valid  = ($urandom % 100) < pv;
    out_ready = ($urandom % 100) < pr;
    rs1_idx = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
    rs2_idx = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
    rd_idx  = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
    rd_we   = 1'($urandom);
    rs1_val = r64(); rs2_val = r64(); rd_val = r64();
    pc_cur = r64(); pc_next = r64(); insn_word = $urandom;
    mem_rd_en = 1'($urandom); mem_wr_en = 1'($urandom);
    mem_bytes = 4'($urandom);
    mem_addr = r64(); mem_rdata = r64(); mem_wdata = r64();
    trap_evt = ($urandom % 5 == 0);
    halt_evt = ($urandom % 7 == 0);
    handler_entry = ($urandom % 6 == 0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    prev_stall = 0; prev_rec = '0;
    rst_n = 0;
    randomize_inputs(0, 0);
    repeat (3) @(negedge clk);
    #2;
    // R1: reset state
    check("R1", "out_valid", 64'(out_valid), 64'd0);
    check("R1", "out_rec nonzero", 64'(out_rec != '0), 64'd0);
    check("R1", "in_ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    rst_n = 1;
    randomize_inputs(100, 0);
    @(negedge clk);
    // R1: first record numbered 1
    #1 check("R1", "first sequence", out_rec[63:0], 64'd1);
    // R5 boundary sizes with both directions
    for (int s = 0; s < 16; s++) begin
      randomize_inputs(100, 100);
      mem_rd_en = 1; mem_wr_en = 1; mem_bytes = 4'(s);
      @(negedge clk);
    end
    for (int i = 0; i < 3000; i++) begin
      randomize_inputs((i < 1500) ? 80 : 40, (i < 1500) ? 60 : 90);
      @(negedge clk);
    end
    in_valid = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    #3;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule